// File: doc/BRIEF.md
# Synchronous Clock Output Stop Controller

This block makes a set of divided clock outputs from one master clock and decides, for each output, whether it runs, parks at a stop level or is held at its disabled level. Two output groups exist. One is a group of single-ended outputs for the peripheral bus, each toggling with period `2*PCI_HALF` master cycles. The other is a group of differential true/complement pairs for the processor, each toggling with period `2*CPU_HALF` master cycles. Every output has its own divider phase: a high half followed by a low half, and the counter behind each group never stops.

Each group has its own active-low stop request. Both requests pass through a two-flop synchronizer. Software marks each output enabled or disabled, and stoppable or free-running, through a small write port. The block samples the new run/park/off decision for an output only at that output's cycle boundary. The outputs therefore never show a shortened pulse, and a restarted output begins with a full high half in phase with its group divider.

Top module: `clkstop_ctl`

## Requirements
- R1: Each running single-ended output has period `2*PCI_HALF` master cycles and each running pair has period `2*CPU_HALF` master cycles, with a 50% duty cycle. A rising edge of the single-ended output or of the true output comes only in the master cycle after the group divider count was 0. After reset the high half comes first.
- R2: While `pci_stop_n` is low, every enabled single-ended output whose free-run bit is 0 is held low. The output parks only after its current cycle ends. The differential pairs keep running.
- R3: A single-ended output whose free-run bit is 1 ignores `pci_stop_n` and keeps toggling.
- R4: When `pci_stop_n` returns high, all stopped single-ended outputs resume within `4*PCI_HALF` master cycles. They restart in the same cycle as one another and in phase with the free-running outputs.
- R5: While `cpu_stop_n` is low, every enabled pair whose free-run bit is 0 parks with the true output high and the complement output low. The single-ended outputs are not affected.
- R6: A pair whose free-run bit is 1 ignores `cpu_stop_n` and keeps toggling.
- R7: An output whose enable bit is 0 is forced to its disabled level, and this takes priority over any stop state. A single-ended output is then low, and both outputs of a pair are low.
- R8: No output ever holds a level for fewer than its half period. The first high phase after a restart lasts the full `PCI_HALF` cycles.
- R9: While `rst_n` is low at a clock edge, all outputs are low. After reset every enable bit and every free-run bit is 0, so all outputs stay low until the configuration is written.
- R10: A write happens at a clock edge where `cfg_we` is 1. Address 0 is the single-ended enable mask, 1 the single-ended free-run mask, 2 the pair enable mask and 3 the pair free-run mask. Bit i of `cfg_wdata` controls output i. A changed bit takes effect only at that output's next cycle boundary, so the cycle that is in progress completes unchanged.
- R11: The true and complement outputs of a pair are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pci_stop_n | input | 1 | Stop request for the single-ended group, active low |
| cpu_stop_n | input | 1 | Stop request for the differential group, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CFG_W | Configuration write data, one bit per output |
| pci_clk | output | N_PCI | Single-ended clock outputs |
| cpu_t | output | N_CPU | True outputs of the differential pairs |
| cpu_c | output | N_CPU | Complement outputs of the differential pairs |

## Verification
The bench builds four single-ended outputs with a half period of 4 and two pairs with a half period of 2. This mix puts stoppable and free-running members in the same group and makes one pair period divide the other. With these values one sampling schedule sees the high and low halves of both groups. The short periods keep the restart latency bound and the cycle-boundary deferral of a configuration write within a few cycles, where they can be measured exactly.

// File: rtl/clkstop_ctl.sv
module clkstop_ctl #(
  parameter int N_PCI    = 4,
  parameter int N_CPU    = 2,
  parameter int PCI_HALF = 4,
  parameter int CPU_HALF = 2,
  parameter int CFG_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pci_stop_n,
  input  logic             cpu_stop_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [N_PCI-1:0] pci_clk,
  output logic [N_CPU-1:0] cpu_t,
  output logic [N_CPU-1:0] cpu_c
);
  localparam int PW = (2*PCI_HALF > 2) ? $clog2(2*PCI_HALF) : 1;
  localparam int CW = (2*CPU_HALF > 2) ? $clog2(2*CPU_HALF) : 1;

  logic [PW-1:0] pci_cnt;
  logic [CW-1:0] cpu_cnt;
  logic [1:0] pci_sync, cpu_sync;
  logic [N_PCI-1:0] pci_en, pci_free, pci_run;
  logic [N_CPU-1:0] cpu_en, cpu_free, cpu_run, cpu_park;
  logic pci_end, cpu_end, pci_hi, cpu_hi;

  assign pci_end = pci_cnt == PW'(2*PCI_HALF-1);
  assign cpu_end = cpu_cnt == CW'(2*CPU_HALF-1);
  assign pci_hi  = pci_cnt < PW'(PCI_HALF);
  assign cpu_hi  = cpu_cnt < CW'(CPU_HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pci_cnt <= '0;
      cpu_cnt <= '0;
    end else begin
      pci_cnt <= pci_end ? '0 : pci_cnt + 1'b1;
      cpu_cnt <= cpu_end ? '0 : cpu_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pci_sync <= 2'b11;
      cpu_sync <= 2'b11;
    end else begin
      pci_sync <= {pci_sync[0], pci_stop_n};
      cpu_sync <= {cpu_sync[0], cpu_stop_n};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pci_en   <= '0;
      pci_free <= '0;
      cpu_en   <= '0;
      cpu_free <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: pci_en   <= cfg_wdata[N_PCI-1:0];
        2'd1: pci_free <= cfg_wdata[N_PCI-1:0];
        2'd2: cpu_en   <= cfg_wdata[N_CPU-1:0];
        default: cpu_free <= cfg_wdata[N_CPU-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pci_run  <= '0;
      cpu_run  <= '0;
      cpu_park <= '0;
    end else begin
      if (pci_end)
        pci_run <= pci_en & (pci_free | {N_PCI{pci_sync[1]}});
      if (cpu_end) begin
        cpu_run  <= cpu_en & (cpu_free | {N_CPU{cpu_sync[1]}});
        cpu_park <= cpu_en & ~cpu_free & {N_CPU{~cpu_sync[1]}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pci_clk <= '0;
      cpu_t   <= '0;
      cpu_c   <= '0;
    end else begin
      pci_clk <= pci_run & {N_PCI{pci_hi}};
      cpu_t   <= (cpu_run & {N_CPU{cpu_hi}}) | cpu_park;
      cpu_c   <= cpu_run & {N_CPU{~cpu_hi}};
    end
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int N_PCI    = 4,
  parameter int N_CPU    = 2,
  parameter int PCI_HALF = 4,
  parameter int CPU_HALF = 2,
  parameter int PW       = 3,
  parameter int CW       = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_PCI-1:0] pci_clk,
  input logic [N_CPU-1:0] cpu_t,
  input logic [N_CPU-1:0] cpu_c,
  input logic [PW-1:0]    pci_cnt,
  input logic [CW-1:0]    cpu_cnt
);
  localparam int NW   = N_PCI + 2*N_CPU;
  localparam int MAXH = (PCI_HALF > CPU_HALF) ? PCI_HALF : CPU_HALF;
  localparam int HW   = $clog2(MAXH + 1) + 1;

  logic [NW-1:0] w, prev_q;
  logic [HW-1:0] held [NW];
  assign w = {cpu_c, cpu_t, pci_clk};

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pci_clk == '0 && cpu_t == '0 && cpu_c == '0));

  for (genvar i = 0; i < NW; i++) begin : g_w
    localparam int H = (i < N_PCI) ? PCI_HALF : CPU_HALF;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        held[i]   <= HW'(H);
      end else begin
        prev_q[i] <= w[i];
        if (w[i] != prev_q[i])   held[i] <= HW'(1);
        else if (held[i] < HW'(H)) held[i] <= held[i] + 1'b1;
      end
    end
    p_min_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (w[i] != prev_q[i]) |-> held[i] >= HW'(H));
  end

  for (genvar i = 0; i < N_PCI; i++) begin : g_p
    p_rise_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pci_clk[i]) |-> $past(pci_cnt) == '0);
  end

  for (genvar j = 0; j < N_CPU; j++) begin : g_c
    p_true_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_t[j]) |-> $past(cpu_cnt) == '0);
    p_pair_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_t[j] && cpu_c[j]));
  end
endmodule

bind clkstop_ctl clkstop_chk #(
  .N_PCI(N_PCI), .N_CPU(N_CPU), .PCI_HALF(PCI_HALF), .CPU_HALF(CPU_HALF),
  .PW(PW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pci_clk(pci_clk), .cpu_t(cpu_t), .cpu_c(cpu_c),
  .pci_cnt(pci_cnt), .cpu_cnt(cpu_cnt)
);

// File: tb/sim_clkstop_ctl.sv
module sim_clkstop_ctl;
  localparam int NP = 4, NC = 2, PH = 4, CH = 2, DW = 8;
  localparam int PP = 2*PH;

  logic clk = 0, rst_n = 0, pci_stop_n = 1, cpu_stop_n = 1, cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [DW-1:0] cfg_wdata = 0;
  logic [NP-1:0] pci_clk;
  logic [NC-1:0] cpu_t, cpu_c;

  clkstop_ctl #(.N_PCI(NP), .N_CPU(NC), .PCI_HALF(PH), .CPU_HALF(CH), .CFG_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pci_clk(pci_clk), .cpu_t(cpu_t), .cpu_c(cpu_c));

  always #5 clk = ~clk;

  typedef struct packed {
    logic [NP-1:0] ph, pl;
    logic [NC-1:0] th, tl, ch, cl;
  } item_t;

  item_t expq[$];
  string tagq[$];
  item_t cur;
  string curtag;
  int checks = 0, fails = 0, done_cnt = 0, tcnt = 0;
  logic [NP-1:0] m_pen = 0, m_pfree = 0;
  logic [NC-1:0] m_cen = 0, m_cfree = 0;

  always @(posedge clk) tcnt <= rst_n ? tcnt + 1 : 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, tcnt);
    end
  endtask

  function automatic int phase();
    return (tcnt - 1) % PP;
  endfunction

  always @(negedge clk) begin
    if (rst_n && tcnt > 0) begin
      if (phase() == 1 && expq.size() > 0) begin
        cur = expq.pop_front();
        curtag = tagq.pop_front();
        chk({curtag, " high pci"}, 8'(pci_clk), 8'(cur.ph));
        chk({curtag, " high true"}, 8'(cpu_t), 8'(cur.th));
        chk({curtag, " high comp"}, 8'(cpu_c), 8'(cur.ch));
        chk("R11 pair exclusive", 8'(cpu_t & cpu_c), 8'd0);
      end else if (phase() == CH + 1 && curtag != "") begin
        chk({curtag, " low true"}, 8'(cpu_t), 8'(cur.tl));
        chk({curtag, " low comp"}, 8'(cpu_c), 8'(cur.cl));
        chk("R11 pair exclusive", 8'(cpu_t & cpu_c), 8'd0);
      end else if (phase() == PH + 1 && curtag != "") begin
        chk({curtag, " low pci"}, 8'(pci_clk), 8'(cur.pl));
        curtag = "";
        done_cnt++;
      end
    end
  end

  task automatic expect_state(string tag);
    item_t it;
    int target;
    for (int i = 0; i < NP; i++) begin
      it.ph[i] = m_pen[i] && (m_pfree[i] || !pci_stop_n);
      it.ph[i] = m_pen[i] && (m_pfree[i] || pci_stop_n);
      it.pl[i] = 1'b0;
    end
    for (int j = 0; j < NC; j++) begin
      if (!m_cen[j]) begin
        it.th[j] = 0; it.tl[j] = 0; it.ch[j] = 0; it.cl[j] = 0;
      end else if (m_cfree[j] || cpu_stop_n) begin
        it.th[j] = 1; it.tl[j] = 0; it.ch[j] = 0; it.cl[j] = 1;
      end else begin
        it.th[j] = 1; it.tl[j] = 1; it.ch[j] = 0; it.cl[j] = 0;
      end
    end
    repeat (3*PP) @(negedge clk);
    target = done_cnt + 1;
    expq.push_back(it);
    tagq.push_back(tag);
    wait (done_cnt == target);
  endtask

  task automatic cfg_write(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    case (a)
      2'd0: m_pen = d[NP-1:0];
      2'd1: m_pfree = d[NP-1:0];
      2'd2: m_cen = d[NC-1:0];
      default: m_cfree = d[NC-1:0];
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    curtag = "";
    repeat (4) @(negedge clk);
    chk("R9 outputs low in reset", 8'({pci_clk, cpu_t, cpu_c}), 8'd0);
    rst_n = 1;
    expect_state("R9 idle after reset");

    cfg_write(2'd0, 8'h0F);
    cfg_write(2'd2, 8'h03);
    expect_state("R1 all running");

    pci_stop_n = 0;
    expect_state("R2 pci stop parks low");

    cfg_write(2'd1, 8'h05);
    expect_state("R3 free-run ignores stop");

    @(negedge clk);
    pci_stop_n = 1;
    lat = 0;
    for (int k = 1; k <= 2*PP + 4; k++) begin
      @(negedge clk);
      if (pci_clk[1]) begin lat = k; break; end
    end
    checks++;
    if (lat == 0 || lat > 2*PP) begin
      fails++;
      $display("FAIL R4 restart latency: actual %0d expected 1..%0d", lat, 2*PP);
    end
    chk("R4 restart in phase", 8'(pci_clk), 8'h0F);
    repeat (PH - 1) @(negedge clk);
    chk("R8 full first high", 8'(pci_clk), 8'h0F);
    @(negedge clk);
    chk("R8 high ends after half", 8'(pci_clk), 8'h00);

    cpu_stop_n = 0;
    expect_state("R5 cpu stop parks pairs");

    cfg_write(2'd3, 8'h02);
    expect_state("R6 free pair runs");

    cfg_write(2'd2, 8'h02);
    cfg_write(2'd0, 8'h03);
    pci_stop_n = 0;
    cfg_write(2'd1, 8'h00);
    expect_state("R7 disabled outputs low");

    pci_stop_n = 1;
    cpu_stop_n = 1;
    cfg_write(2'd0, 8'h0F);
    expect_state("R10 map reenable");

    do @(negedge clk); while (phase() != 0);
    cfg_we = 1; cfg_addr = 2'd0; cfg_wdata = 8'h06; m_pen = 4'h6;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    chk("R10 cycle in progress kept", 8'(pci_clk), 8'h0F);
    do @(negedge clk); while (phase() != 0);
    chk("R10 applied at boundary", 8'(pci_clk), 8'h06);
    expect_state("R10 new mask steady");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule